// File: doc/BRIEF.md
# One-Second Timing Strobe with Counter Snapshot

This block turns a slow reference clock (nominally 8 kHz) into a once-per-second timing mark and uses that mark to freeze a bank of live event counters. The reference is brought into the system clock domain and divided by a parameter (8000 by default). The divided signal is high for the first half of each count cycle.

A single bidirectional pad carries the one-second mark. One direction bit sets the pad's role. As an output, the pad drives the locally generated mark. As an input, the pad's driver is released and an externally supplied mark is synchronized and used in place of the local one.

Each rising edge of whichever mark is active starts a snapshot. In that clock cycle, every live counter is copied into its holding register and restarted. A one-cycle flag shows when the holding registers have just taken new values. The live counters stop at their maximum value instead of wrapping.

Top module: `sec_strobe_snap`

## Requirements
- R1: While reset is held low and after it is released, before any stimulus: `snap_done` is 0, every holding register reads 0, `sec_pin_oe` equals `dir_out`, and `sec_pin_o` equals `dir_out` (the divider starts at count 0, which is in the high half).
- R2: With `dir_out`=1, after k rising edges of `ref_in`, `sec_pin_o` is 1 when (k mod DIV_COUNT) < DIV_COUNT/2 and 0 otherwise. A rising edge of `ref_in` first sampled high at clock edge m changes `sec_pin_o` after clock edge m+2.
- R3: `dir_out`=1 (output) sets `sec_pin_oe` to 1. `dir_out`=0 (input) sets `sec_pin_oe` to 0 and holds `sec_pin_o` at 0.
- R4: With `dir_out`=1, a snapshot is taken once per DIV_COUNT reference rising edges. It happens at the clock edge after the divider count returns to 0.
- R5: With `dir_out`=0, suppose `sec_pin_i` is sampled low at clock edge m-1 and high at clock edge m. Then the snapshot takes effect at clock edge m+2. A high level lasting one clock cycle is enough.
- R6: At a snapshot, each holding register takes the live count accumulated since the previous snapshot (or since reset). Each live counter then restarts. An event sampled at the snapshot edge is counted as 1 in the new interval.
- R7: A live counter that reaches 2^CNT_W-1 stays there until the next snapshot. Further events do not wrap it.
- R8: `snap_done` is 1 for exactly one clock cycle, the cycle in which the holding registers show their new values. The holding registers do not change in any other cycle.
- R9: The inactive source is ignored. In input mode, `ref_in` activity causes no snapshot. In output mode, `sec_pin_i` activity causes no snapshot.
- R10: Leaving reset does not by itself cause a snapshot, even though the generated mark starts high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Slow reference clock, asynchronous to clk |
| dir_out | input | 1 | Pad direction: 1 = drive the generated mark, 0 = accept an external mark |
| sec_pin_i | input | 1 | Pad input value (external mark) |
| sec_pin_o | output | 1 | Pad output value (generated mark, 0 in input mode) |
| sec_pin_oe | output | 1 | Pad output enable |
| event_in | input | NUM_CNT | One event strobe per counter, counted once per cycle when high |
| held_flat | output | NUM_CNT*CNT_W | Holding registers; counter c occupies bits [c*CNT_W +: CNT_W] |
| snap_done | output | 1 | One-cycle flag: holding registers were just updated |

## Verification
A divider count that is off by one shows up within one count cycle. The pad output toggles at the wrong reference edge, and the snapshot flag comes one reference period early or late. A snapshot that fires at the wrong time or is missed shows on `snap_done` in the next clock cycle. A live counter that loses or gains one event is hidden until the next snapshot, when its holding register reads a different value. The bench compares every cycle against an arithmetic model of the synchronizer latency, the divider and the counters. It does this in both pad directions and with a counter width small enough to reach saturation.

// File: rtl/sss_pkg.sv
// Shared definitions for the one-second strobe and snapshot block.
package sss_pkg;

    // Direction of the one-second pad.
    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } pin_dir_e;

endpackage

// File: rtl/sss_sync.sv
// Two-flop synchronizer, one per bit.
// Assumes: each input bit is a level, so no pulse shorter than a clk period
// needs to be caught.
module sss_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    // Two flop stages bring the asynchronous inputs into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/sss_divider.sv
// Divides the synchronized reference by DIV.
// The output is high while the count is below HIGH_LEN.
// Assumes: ref_s is already synchronized, and the reference is slow enough
// that each of its high and low phases lasts at least one clk cycle.
module sss_divider #(
    parameter int DIV      = 8000,
    parameter int HIGH_LEN = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_s,
    output logic strobe
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HI   = CW'(HIGH_LEN);

    logic          ref_prev_q;
    logic          ref_rise;
    logic [CW-1:0] cnt_q;

    assign ref_rise = ref_s & ~ref_prev_q;

    // Keep the previous reference level so its rising edge can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_prev_q <= 1'b0;
        else        ref_prev_q <= ref_s;
    end

    // Count reference rising edges modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (ref_rise) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign strobe = (cnt_q < HI);

endmodule

// File: rtl/sss_edge.sv
// Rising-edge detector on a synchronous level.
// Assumes: lvl is synchronous to clk. The stored level resets high, so a
// level that is already high when reset ends is not taken as an edge.
module sss_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic prev_q;

    // Keep the previous level of the active one-second signal.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

endmodule

// File: rtl/sss_counter_bank.sv
// Bank of saturating live event counters, each with a holding register.
// On snap, each holding register takes its live count, and the live counter
// restarts at 0 or 1 (1 if an event arrives in that same cycle).
// Assumes: ev is synchronous to clk; one event per counter per cycle.
module sss_counter_bank #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         snap,
    output logic [N*W-1:0] live_flat,
    output logic [N*W-1:0] held_flat,
    output logic         done
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [W-1:0] live_q;
        logic [W-1:0] held_q;

        // Live count: restart at a snapshot, otherwise count up and stop at max.
        always_ff @(posedge clk) begin
            if (!rst_n)                    live_q <= '0;
            else if (snap)                 live_q <= W'(ev[g]);
            else if (ev[g] && live_q != MAXV) live_q <= live_q + 1'b1;
        end

        // Holding register: copy the live count at a snapshot.
        always_ff @(posedge clk) begin
            if (!rst_n)    held_q <= '0;
            else if (snap) held_q <= live_q;
        end

        assign live_flat[g*W +: W] = live_q;
        assign held_flat[g*W +: W] = held_q;
    end

    // One-cycle flag that marks fresh holding-register contents.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= snap;
    end

endmodule

// File: rtl/sec_strobe_snap.sv
// One-second strobe generator and counter snapshot.
// Synchronizes the slow reference and the pad input. The pad drives the
// divided reference when dir_out is 1, and takes an external mark when
// dir_out is 0. Each rising edge of the active mark triggers a snapshot.
// Assumes: ref_in and sec_pin_i are asynchronous levels, much slower than clk.
module sec_strobe_snap
    import sss_pkg::*;
#(
    parameter int DIV_COUNT = 8000,
    parameter int NUM_CNT   = 4,
    parameter int CNT_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ref_in,
    input  logic                     dir_out,
    input  logic                     sec_pin_i,
    output logic                     sec_pin_o,
    output logic                     sec_pin_oe,
    input  logic [NUM_CNT-1:0]       event_in,
    output logic [NUM_CNT*CNT_W-1:0] held_flat,
    output logic                     snap_done
);

    localparam int HIGH_LEN = DIV_COUNT / 2;

    pin_dir_e                 dir;
    logic [1:0]               sync_q;
    logic                     gen_mark;
    logic                     active_mark;
    logic                     snap_now;
    logic [NUM_CNT*CNT_W-1:0] live_flat;

    assign dir = pin_dir_e'(dir_out);

    sss_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sec_pin_i, ref_in}),
        .q     (sync_q)
    );

    sss_divider #(.DIV(DIV_COUNT), .HIGH_LEN(HIGH_LEN)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_s  (sync_q[0]),
        .strobe (gen_mark)
    );

    // Choose the mark that drives snapshots, and drive the pad.
    always_comb begin
        active_mark = (dir == DIR_OUT) ? gen_mark : sync_q[1];
        sec_pin_oe  = (dir == DIR_OUT);
        sec_pin_o   = (dir == DIR_OUT) & gen_mark;
    end

    sss_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (active_mark),
        .rise  (snap_now)
    );

    sss_counter_bank #(.N(NUM_CNT), .W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (event_in),
        .snap      (snap_now),
        .live_flat (live_flat),
        .held_flat (held_flat),
        .done      (snap_done)
    );

endmodule

// File: rtl/sec_strobe_snap_chk.sv
// Assertion checker for sec_strobe_snap, attached with bind below.
module sec_strobe_snap_chk #(
    parameter int N = 4,
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dir_out,
    input logic         sec_pin_o,
    input logic         sec_pin_oe,
    input logic         snap_now,
    input logic         snap_done,
    input logic [N*W-1:0] live_flat,
    input logic [N*W-1:0] held_flat
);

    // R3
    pad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_pin_oe |-> !sec_pin_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_done |=> !snap_done);

    // R8
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_done |-> $stable(held_flat));

    // R6
    copy_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_now |=> (snap_done && held_flat == $past(live_flat)));

    // R4
    out_rise_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && $past(dir_out) && $rose(sec_pin_o)) |-> snap_now);

    for (genvar g = 0; g < N; g++) begin : g_sat
        // R7
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (live_flat[g*W +: W] == {W{1'b1}} && !snap_now)
                |=> live_flat[g*W +: W] == {W{1'b1}});
    end

endmodule

bind sec_strobe_snap sec_strobe_snap_chk #(.N(NUM_CNT), .W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_out    (dir_out),
    .sec_pin_o  (sec_pin_o),
    .sec_pin_oe (sec_pin_oe),
    .snap_now   (snap_now),
    .snap_done  (snap_done),
    .live_flat  (live_flat),
    .held_flat  (held_flat)
);

// File: tb/sec_strobe_snap_test.sv
// Cycle-by-cycle bench using an arithmetic model of sec_strobe_snap.
module sec_strobe_snap_test;

    localparam int DIV  = 8;
    localparam int N    = 3;
    localparam int W    = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_in = 1'b0;
    logic         dir_out = 1'b0;
    logic         sec_pin_i = 1'b0;
    logic         sec_pin_o;
    logic         sec_pin_oe;
    logic [N-1:0] event_in = '0;
    logic [N*W-1:0] held_flat;
    logic         snap_done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    int live_m [N];
    int held_m [N];
    int refcnt;
    bit rh [5];
    bit ph [4];
    string tag;

    always #2.5 clk = ~clk;

    sec_strobe_snap #(.DIV_COUNT(DIV), .NUM_CNT(N), .CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dir_out(dir_out),
        .sec_pin_i(sec_pin_i), .sec_pin_o(sec_pin_o), .sec_pin_oe(sec_pin_oe),
        .event_in(event_in), .held_flat(held_flat), .snap_done(snap_done)
    );

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < N; c++) begin
            live_m[c] = 0;
            held_m[c] = 0;
        end
        refcnt = 0;
        for (int i = 0; i < 5; i++) rh[i] = 0;
        for (int i = 0; i < 4; i++) ph[i] = 0;
    endtask

    // Reset with the given direction, then check the state right after reset (R1).
    task automatic do_reset(bit dir);
        @(negedge clk);
        rst_n = 1'b0; dir_out = dir; ref_in = 1'b0; sec_pin_i = 1'b0; event_in = '0;
        repeat (4) @(posedge clk);
        #1;
        check("R1", snap_done, 0, "snap_done in reset");
        check("R1", held_flat, 0, "held in reset");
        check("R1", sec_pin_oe, dir, "oe in reset");
        check("R1", sec_pin_o, dir, "pin_o in reset");
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // Drive one cycle of stimulus, update the model, and compare after the edge.
    task automatic step(bit r, bit p, logic [N-1:0] ev);
        bit snap_e;
        @(negedge clk);
        ref_in = r; sec_pin_i = p; event_in = ev;
        @(posedge clk);
        #1;
        for (int i = 4; i > 0; i--) rh[i] = rh[i-1];
        rh[0] = r;
        for (int i = 3; i > 0; i--) ph[i] = ph[i-1];
        ph[0] = p;
        if (dir_out) begin
            snap_e = rh[3] && !rh[4] && (refcnt % DIV == 0) && refcnt > 0;
            if (rh[2] && !rh[3]) refcnt++;
        end else begin
            snap_e = ph[2] && !ph[3];
        end
        for (int c = 0; c < N; c++) begin
            if (snap_e) begin
                held_m[c] = live_m[c];
                live_m[c] = ev[c] ? 1 : 0;
            end else if (ev[c] && live_m[c] < MAXV) begin
                live_m[c]++;
            end
        end
        check(tag, snap_done, snap_e, "snap_done");
        for (int c = 0; c < N; c++)
            check(tag, held_flat[c*W +: W], held_m[c], $sformatf("held[%0d]", c));
        check("R3", sec_pin_oe, dir_out, "oe");
        if (dir_out)
            check("R2", sec_pin_o, ((refcnt % DIV) < DIV/2) ? 1 : 0, "pin_o");
        else
            check("R3", sec_pin_o, 0, "pin_o in input mode");
    endtask

    initial begin
        // Input mode (R1, R3, R5, R6, R9).
        do_reset(1'b0);
        tag = "R5";
        for (int i = 0; i < 80; i++)
            step(((i / 2) % 2) == 1, (i % 10) >= 5,
                 {(i % 3) == 0, (i % 2) == 1, 1'b1});
        // Single-cycle pulses on the pad, with events in the snapshot cycle (R5, R6).
        tag = "R6";
        for (int i = 0; i < 40; i++)
            step(1'b0, (i % 8) == 3, {(i % 4) == 1, (i % 5) == 0, 1'b1});
        // Saturation (R7).
        tag = "R7";
        for (int i = 0; i < 30; i++) step(1'b0, 1'b0, {1'b1, 1'b1, (i % 2) == 0});
        for (int i = 0; i < 8; i++)  step(1'b0, i >= 2, '1);
        // Ref activity alone in input mode gives no snapshot (R9).
        tag = "R9";
        for (int i = 0; i < 24; i++) step((i % 4) < 2, 1'b1, 3'b101);

        // Output mode (R1, R2, R4, R9, R10).
        do_reset(1'b1);
        tag = "R10";
        for (int i = 0; i < 12; i++) step(1'b0, (i % 3) == 0, 3'b011);
        tag = "R4";
        for (int i = 0; i < 20 * 6; i++)
            step((i % 6) < 3, (i % 4) < 2, {(i % 5) == 0, (i % 2) == 0, 1'b1});
        tag = "R9";
        for (int i = 0; i < 16; i++) step(1'b0, (i % 2) == 0, 3'b110);

        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule